// File: doc/BRIEF.md
# Store Queue with Read-Miss Address Check

This block sits between a write-through data cache and a slower main memory. Every store the processor performs is written into the cache and, in the same cycle, offered to this queue as an address/data pair. The memory side takes the oldest queued store through a valid/ready handshake and retires one write per accepted transfer. The queue therefore lets the processor run ahead of memory while keeping the stores in their program order.

When the cache misses on a load, the miss address is presented on a check port before the read is sent to memory. The block compares the block number of that address with every occupied slot, and also with a store being accepted in the same cycle. If nothing matches, the read may go ahead of all pending stores at once. If something matches, the read is held back until every matching store has left the queue, so the memory never returns data that is older than a store already issued.

Top module: `wt_write_queue`

## Requirements
- R1: With default parameters the queue holds 4 stores; `push_ready` stays high until 4 stores are held and is low once the queue is full.
- R2: Stores leave on the drain port in the exact order they were accepted, with the address and data they were pushed with.
- R3: `drain_valid` is high exactly when at least one store is held; a store is removed only on a cycle with `drain_valid` and `drain_ready` both high, and while `drain_ready` is low the offered address and data do not change.
- R4: A push offered while the queue is full is not taken and not lost: the queue contents stay as they were, and the same push is accepted on the first edge after a slot frees while `push_valid` is kept high.
- R5: With `chk_valid` high and no matching store, `chk_go` is high and `chk_hold` low in that same cycle, however many unrelated stores are queued.
- R6: With `chk_valid` high and a matching store queued, `chk_hold` is high and `chk_go` low; `chk_hold` stays high during the cycle in which the last matching store is drained and falls in the cycle after.
- R7: Addresses are compared by block: the lowest `OFS_W` bits (4 by default, 16-byte blocks) are ignored, so 0x100F matches a queued 0x1000 while 0x1010 does not.
- R8: A push and a drain on the same edge leave the number of held stores unchanged.
- R9: A store being accepted in the same cycle as a check counts as queued: if its block matches the check address, `chk_hold` is high in that cycle.
- R10: After reset the queue is empty: `drain_valid` low, `push_ready` high, `chk_hold` low.
- R11: With `chk_valid` low, both `chk_go` and `chk_hold` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Processor offers a store |
| push_ready | output | 1 | Queue can take a store this cycle |
| push_addr | input | ADDR_W | Store byte address |
| push_data | input | DATA_W | Store data |
| drain_valid | output | 1 | Oldest store is offered to memory |
| drain_ready | input | 1 | Memory takes the offered store |
| drain_addr | output | ADDR_W | Address of the oldest store |
| drain_data | output | DATA_W | Data of the oldest store |
| chk_valid | input | 1 | A read miss asks for clearance |
| chk_addr | input | ADDR_W | Read-miss byte address |
| chk_go | output | 1 | No conflicting store; the read may proceed |
| chk_hold | output | 1 | A conflicting store is queued; the read must wait |

## Verification
Two pairs of functions can land in one cycle: a drain together with a push, and a check together with either a drain of the matching store or the push of a matching store. The bench drives both handshakes in one cycle on a queue one slot short of full and then judges the occupancy by whether exactly one further push is taken before `push_ready` falls. It keeps a check open while the queue drains and expects `chk_hold` high through the cycle that removes the last matching store and low in the next, and it offers a check beside a push of the same block into an empty queue and expects the hold at once.

// File: rtl/wq_pkg.sv
package wq_pkg;

    localparam int unsigned WQ_DEPTH_DEF  = 4;
    localparam int unsigned WQ_ADDR_W_DEF = 32;
    localparam int unsigned WQ_DATA_W_DEF = 32;
    localparam int unsigned WQ_OFS_W_DEF  = 4;

    typedef enum logic [1:0] {
        OCC_KEEP = 2'd0,
        OCC_UP   = 2'd1,
        OCC_DOWN = 2'd2
    } occ_step_e;

    function automatic occ_step_e occ_step(input logic in_fire, input logic out_fire);
        if (in_fire && !out_fire) begin
            return OCC_UP;
        end else if (out_fire && !in_fire) begin
            return OCC_DOWN;
        end
        return OCC_KEEP;
    endfunction

endpackage

// File: rtl/wq_ctrl.sv
module wq_ctrl
    import wq_pkg::*;
#(
    parameter int unsigned DEPTH = WQ_DEPTH_DEF
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  push_req,
    input  logic                                  pop_req,
    output logic                                  push_ok,
    output logic                                  pop_ok,
    output logic                                  push_fire,
    output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] wr_idx,
    output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rd_idx,
    output logic [DEPTH-1:0]                      live
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic [DEPTH-1:0] live;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic  pop_fire;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    assign push_ok   = (st_q.cnt != FULL_CNT);
    assign pop_ok    = (st_q.cnt != '0);
    assign push_fire = push_req && push_ok;
    assign pop_fire  = pop_req && pop_ok;
    assign wr_idx    = st_q.wr;
    assign rd_idx    = st_q.rd;
    assign live      = st_q.live;

    always_comb begin
        st_d = st_q;
        if (push_fire) begin
            st_d.wr = wrap_inc(st_q.wr);
            st_d.live[st_q.wr] = 1'b1;
        end
        if (pop_fire) begin
            st_d.rd = wrap_inc(st_q.rd);
            st_d.live[st_q.rd] = 1'b0;
        end
        case (occ_step(push_fire, pop_fire))
            OCC_UP:   st_d.cnt = st_q.cnt + CNT_W'(1);
            OCC_DOWN: st_d.cnt = st_q.cnt - CNT_W'(1);
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT); // R1

    AST_LIVE_TRACKS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.live) == int'(st_q.cnt)); // R1

    AST_BOTH_FIRE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        push_fire && pop_fire |=> st_q.cnt == $past(st_q.cnt)); // R8

endmodule

// File: rtl/wq_store.sv
module wq_store
    import wq_pkg::*;
#(
    parameter int unsigned DEPTH  = WQ_DEPTH_DEF,
    parameter int unsigned ADDR_W = WQ_ADDR_W_DEF,
    parameter int unsigned DATA_W = WQ_DATA_W_DEF
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] wr_idx,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [DATA_W-1:0]                     wr_data,
    input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rd_idx,
    output logic [ADDR_W-1:0]                     rd_addr,
    output logic [DATA_W-1:0]                     rd_data,
    output logic [DEPTH*ADDR_W-1:0]               all_addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t [DEPTH-1:0] mem_q, mem_d;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx].addr = wr_addr;
            mem_d[wr_idx].data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_addr = mem_q[rd_idx].addr;
    assign rd_data = mem_q[rd_idx].data;

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign all_addr[g*ADDR_W +: ADDR_W] = mem_q[g].addr;
    end

endmodule

// File: rtl/wq_match.sv
module wq_match
    import wq_pkg::*;
#(
    parameter int unsigned DEPTH  = WQ_DEPTH_DEF,
    parameter int unsigned ADDR_W = WQ_ADDR_W_DEF,
    parameter int unsigned OFS_W  = WQ_OFS_W_DEF
) (
    input  logic [DEPTH*ADDR_W-1:0] all_addr,
    input  logic [DEPTH-1:0]        live,
    input  logic [ADDR_W-1:0]       probe_addr,
    input  logic                    new_en,
    input  logic [ADDR_W-1:0]       new_addr,
    output logic                    hit
);

    localparam int unsigned TAG_W = ADDR_W - OFS_W;

    logic [TAG_W-1:0] probe_tag;
    logic [DEPTH-1:0] slot_hit;
    logic             new_hit;
    logic             unused_low;

    assign probe_tag = probe_addr[ADDR_W-1:OFS_W];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [TAG_W-1:0] slot_tag;
        logic             unused_slot_low;
        assign slot_tag        = all_addr[g*ADDR_W + OFS_W +: TAG_W];
        assign unused_slot_low = ^all_addr[g*ADDR_W +: OFS_W];
        assign slot_hit[g]     = live[g] && (slot_tag == probe_tag);
    end

    assign new_hit    = new_en && (new_addr[ADDR_W-1:OFS_W] == probe_tag);
    assign hit        = (|slot_hit) || new_hit;
    assign unused_low = ^{probe_addr[OFS_W-1:0], new_addr[OFS_W-1:0]};

endmodule

// File: rtl/wt_write_queue.sv
module wt_write_queue
    import wq_pkg::*;
#(
    parameter int unsigned DEPTH  = WQ_DEPTH_DEF,
    parameter int unsigned ADDR_W = WQ_ADDR_W_DEF,
    parameter int unsigned DATA_W = WQ_DATA_W_DEF,
    parameter int unsigned OFS_W  = WQ_OFS_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    output logic              drain_valid,
    input  logic              drain_ready,
    output logic [ADDR_W-1:0] drain_addr,
    output logic [DATA_W-1:0] drain_data,
    input  logic              chk_valid,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_go,
    output logic              chk_hold
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic                    push_fire;
    logic [PTR_W-1:0]        wr_idx;
    logic [PTR_W-1:0]        rd_idx;
    logic [DEPTH-1:0]        live;
    logic [DEPTH*ADDR_W-1:0] all_addr;
    logic                    conflict;

    wq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_valid),
        .pop_req   (drain_ready),
        .push_ok   (push_ready),
        .pop_ok    (drain_valid),
        .push_fire (push_fire),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .live      (live)
    );

    wq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push_fire),
        .wr_idx   (wr_idx),
        .wr_addr  (push_addr),
        .wr_data  (push_data),
        .rd_idx   (rd_idx),
        .rd_addr  (drain_addr),
        .rd_data  (drain_data),
        .all_addr (all_addr)
    );

    wq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_match (
        .all_addr   (all_addr),
        .live       (live),
        .probe_addr (chk_addr),
        .new_en     (push_fire),
        .new_addr   (push_addr),
        .hit        (conflict)
    );

    assign chk_go   = chk_valid && !conflict;
    assign chk_hold = chk_valid && conflict;

    AST_DRAIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid && !drain_ready |=> drain_valid && $stable(drain_addr) && $stable(drain_data)); // R3

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !push_ready && !drain_ready |=> !push_ready); // R4

    AST_GO_HOLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_go && chk_hold)); // R5

    AST_EMPTY_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !drain_valid && !push_valid |-> !chk_hold); // R6

endmodule

// File: tb/sim_wt_write_queue.sv
`timescale 1ns/100ps
module sim_wt_write_queue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic        push_ready;
    logic [31:0] push_addr = '0;
    logic [31:0] push_data = '0;
    logic        drain_valid;
    logic        drain_ready = 1'b0;
    logic [31:0] drain_addr;
    logic [31:0] drain_data;
    logic        chk_valid = 1'b0;
    logic [31:0] chk_addr = '0;
    logic        chk_go;
    logic        chk_hold;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    wt_write_queue u0 (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_ready(push_ready),
        .push_addr(push_addr), .push_data(push_data),
        .drain_valid(drain_valid), .drain_ready(drain_ready),
        .drain_addr(drain_addr), .drain_data(drain_data),
        .chk_valid(chk_valid), .chk_addr(chk_addr),
        .chk_go(chk_go), .chk_hold(chk_hold)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
    } push_vec_t;

    typedef struct packed {
        logic [31:0] addr;
        logic        en;
        logic        hold;
        logic        go;
    } probe_vec_t;

    localparam push_vec_t PUSH_TBL [4] = '{
        '{32'h0000_1000, 32'h0000_00A0},
        '{32'h0000_2004, 32'h0000_00A1},
        '{32'h0000_3008, 32'h0000_00A2},
        '{32'h0000_100C, 32'h0000_00A3}
    };

    localparam probe_vec_t PROBE_TBL [8] = '{
        '{32'h0000_1000, 1'b1, 1'b1, 1'b0},
        '{32'h0000_100F, 1'b1, 1'b1, 1'b0},
        '{32'h0000_1010, 1'b1, 1'b0, 1'b1},
        '{32'h0000_2000, 1'b1, 1'b1, 1'b0},
        '{32'h0000_4000, 1'b1, 1'b0, 1'b1},
        '{32'h0000_300F, 1'b1, 1'b1, 1'b0},
        '{32'h0000_3010, 1'b1, 1'b0, 1'b1},
        '{32'h0000_1000, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_a [4];
        logic [31:0] exp_d [4];
        logic        exp_h [4];
        exp_a = '{32'h2004, 32'h3008, 32'h100C, 32'h5000};
        exp_d = '{32'hA1, 32'hA2, 32'hA3, 32'h55};
        exp_h = '{1'b1, 1'b1, 1'b1, 1'b0};

        // R10: reset state
        repeat (3) step();
        check("R10 drain_valid", {31'b0, drain_valid}, 32'd0);
        check("R10 push_ready", {31'b0, push_ready}, 32'd1);
        rst_n = 1'b1;
        chk_valid = 1'b1;
        chk_addr  = 32'h1000;
        #1;
        check("R10 chk_hold", {31'b0, chk_hold}, 32'd0);
        chk_valid = 1'b0;
        step();

        // R1: fill from the push table
        for (int i = 0; i < 4; i++) begin
            push_valid = 1'b1;
            push_addr  = PUSH_TBL[i].addr;
            push_data  = PUSH_TBL[i].data;
            #1;
            check("R1 ready below depth", {31'b0, push_ready}, 32'd1);
            step();
        end
        push_valid = 1'b0;
        #1;
        check("R1 ready at depth", {31'b0, push_ready}, 32'd0);
        check("R2 head addr", drain_addr, 32'h1000);
        check("R3 drain_valid when held", {31'b0, drain_valid}, 32'd1);

        // R5 R7 R11: probe table against the full queue
        for (int i = 0; i < 8; i++) begin
            chk_valid = PROBE_TBL[i].en;
            chk_addr  = PROBE_TBL[i].addr;
            #1;
            check("R5/R7/R11 hold", {31'b0, chk_hold}, {31'b0, PROBE_TBL[i].hold});
            check("R5/R7/R11 go", {31'b0, chk_go}, {31'b0, PROBE_TBL[i].go});
        end
        chk_valid = 1'b0;
        step();

        // R4: push stalls while full
        push_valid = 1'b1;
        push_addr  = 32'h5000;
        push_data  = 32'h55;
        step();
        step();
        check("R4 still full", {31'b0, push_ready}, 32'd0);
        check("R4 head unchanged", drain_addr, 32'h1000);
        check("R3 data stable", drain_data, 32'hA0);
        drain_ready = 1'b1;
        step();
        drain_ready = 1'b0;
        #1;
        check("R4 slot freed", {31'b0, push_ready}, 32'd1);
        step();
        push_valid = 1'b0;
        #1;
        check("R4 stalled push taken", {31'b0, push_ready}, 32'd0);

        // R2 R6: drain everything with a check open on block 0x100
        chk_valid   = 1'b1;
        chk_addr    = 32'h1000;
        drain_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            #1;
            check("R2 drain order addr", drain_addr, exp_a[k]);
            check("R2 drain order data", drain_data, exp_d[k]);
            check("R6 hold until drained", {31'b0, chk_hold}, {31'b0, exp_h[k]});
            step();
        end
        drain_ready = 1'b0;
        #1;
        check("R6 go after drain", {31'b0, chk_go}, 32'd1);
        chk_valid = 1'b0;
        check("R3 empty", {31'b0, drain_valid}, 32'd0);

        // R8: push and drain on one edge
        for (int i = 1; i <= 3; i++) begin
            push_valid = 1'b1;
            push_addr  = 32'(i * 16);
            push_data  = 32'(i);
            step();
        end
        push_addr   = 32'h40;
        push_data   = 32'h4;
        drain_ready = 1'b1;
        #1;
        check("R8 head before", drain_addr, 32'h10);
        step();
        drain_ready = 1'b0;
        push_addr   = 32'h50;
        push_data   = 32'h5;
        #1;
        check("R8 one slot left", {31'b0, push_ready}, 32'd1);
        step();
        push_valid = 1'b0;
        #1;
        check("R8 full after one push", {31'b0, push_ready}, 32'd0);
        check("R8 head after", drain_addr, 32'h20);
        drain_ready = 1'b1;
        repeat (4) step();
        drain_ready = 1'b0;
        #1;
        check("R8 drained", {31'b0, drain_valid}, 32'd0);

        // R9: check beside a push of the same block
        push_valid = 1'b1;
        push_addr  = 32'h7000;
        push_data  = 32'h7;
        chk_valid  = 1'b1;
        chk_addr   = 32'h7004;
        #1;
        check("R9 hold on same-cycle push", {31'b0, chk_hold}, 32'd1);
        chk_addr = 32'h7010;
        #1;
        check("R9 go on other block", {31'b0, chk_go}, 32'd1);
        step();
        push_valid = 1'b0;
        chk_addr   = 32'h7008;
        #1;
        check("R9 hold once stored", {31'b0, chk_hold}, 32'd1);
        chk_valid = 1'b0;

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule